// File: doc/BRIEF.md
# Indexed-Access Real-Time Clock Core

This block keeps calendar time (seconds, minutes, hours, day of month, month and a two-digit year). Software reaches it through two byte-wide ports. A write on the select port stores a register index. A write on the data port then updates the register at that index. The read bus always shows the register that is currently selected. Time fields are presented either in binary or in packed BCD. A mode bit in the control register picks the format.

Time advances on a one-second boundary, derived by counting `tickIn` pulses from an external prescaler source. Software sets the clock with a two-step handshake:

1. It raises the freeze bit and holds the divider in reset.
2. It loads the fields, clears the freeze bit and then releases the divider. The first update comes half a second after the release.

A read-only update flag rises a fixed number of ticks before every rollover. Software can therefore tell whether a multi-byte read might straddle an update.

Top module: `rtcIdxCore`

## Requirements
- R1: A `selWr` pulse stores `wrData` as the index. A `dataWr` pulse writes `wrData` to the register at the stored index. `rdData` continuously shows the selected register. The indices are:
  - seconds 0x00, minutes 0x02, hours 0x04, day 0x07, month 0x08, year 0x09;
  - rate/status 0x0A, control 0x0B.
  Every other index reads 0x00, and writes to it change nothing.
- R2: After reset the time is 00:00:00 on day 1 of month 1, year 00. The control register and the rate/status register both read 0x00.
- R3: Control bit 2 selects binary format when set and packed BCD (tens in bits 7:4) when clear. Time fields are written and read in the format selected at the moment of access.
- R4: While control bit 7 (freeze) is 1, no time field advances and the update flag reads 0.
- R5: When rate/status bits 6:5 equal 2'b11, the prescaler is held. While it is held, no time field advances and the update flag reads 0.
- R6: After the hold in R5 is released, the first advance occurs on the edge that takes the `TICKS_PER_SEC/2`-th tick after the release. Later advances follow every `TICKS_PER_SEC` ticks.
- R7: Rate/status bit 7 (the update flag) is 1 exactly for the last `UIP_LEAD` ticks before each advance. It falls on the same edge where the fields update. Time fields change only on a data write, or on an edge at which the flag was 1.
- R8: An advance carries seconds 59 into the next minute, minutes 59 into the next hour and hour 23 into the next day. Month 12 rolls to month 1 of the next year, and year 99 wraps to 00. Hours are 24-hour only.
- R9: The day rolls over after 31 days in months 1, 3, 5, 7, 8, 10 and 12, and after 30 days in months 4, 6, 9 and 11. February has 29 days when the year is divisible by 4 and 28 otherwise.
- R10: Writes to rate/status bit 7 are ignored, and bits 6:0 read back as written. In the control register, only bits 7 and 2 are stored; the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle prescaler tick pulse |
| selWr | input | 1 | Store `wrData` as register index |
| dataWr | input | 1 | Write `wrData` to selected register |
| wrData | input | 8 | Write byte for index or data |
| rdData | output | 8 | Contents of the selected register |

## Verification
The assertions assume the following about the inputs:
- `tickIn` is a single-cycle pulse.
- Software writes only in-range, calendar-consistent values to the time fields.

Under those assumptions the field ranges are an invariant across every cycle without a write. The stimulus sets time only through the freeze-and-hold sequence, and uses valid dates for the leap-year, month-end and year-end cases. It pulses `tickIn` every other clock, which keeps the half-second and flag-lead windows short. The only out-of-range writes are to unmapped indices and to read-only bits, which the block must drop.

// File: rtl/rtcIdxPkg.sv
package rtcIdxPkg;
  localparam int FIELD_W = 7;
  localparam int NUM_FIELDS = 6;

  localparam int IX_SEC  = 0;
  localparam int IX_MIN  = 1;
  localparam int IX_HOUR = 2;
  localparam int IX_DAY  = 3;
  localparam int IX_MON  = 4;
  localparam int IX_YEAR = 5;

  localparam logic [7:0] IDX_SEC  = 8'h00;
  localparam logic [7:0] IDX_MIN  = 8'h02;
  localparam logic [7:0] IDX_HOUR = 8'h04;
  localparam logic [7:0] IDX_DAY  = 8'h07;
  localparam logic [7:0] IDX_MON  = 8'h08;
  localparam logic [7:0] IDX_YEAR = 8'h09;
  localparam logic [7:0] IDX_RATE = 8'h0A;
  localparam logic [7:0] IDX_CTL  = 8'h0B;

  typedef enum logic [2:0] {
    FLD_SEC, FLD_MIN, FLD_HOUR, FLD_DAY, FLD_MON, FLD_YEAR, FLD_NONE
  } fieldSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      advance;
    logic      wrEn;
    fieldSel_e wrField;
    fieldSel_e rdField;
    logic      binMode;
  } dpStrobe_t;

  typedef struct packed {
    logic [FIELD_W-1:0] sec;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] day;
    logic [FIELD_W-1:0] mon;
    logic [FIELD_W-1:0] year;
  } calTime_t;

  function automatic fieldSel_e indexToField(input logic [7:0] idx);
    case (idx)
      IDX_SEC:  return FLD_SEC;
      IDX_MIN:  return FLD_MIN;
      IDX_HOUR: return FLD_HOUR;
      IDX_DAY:  return FLD_DAY;
      IDX_MON:  return FLD_MON;
      IDX_YEAR: return FLD_YEAR;
      default:  return FLD_NONE;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] daysIn(input logic [FIELD_W-1:0] mon,
                                                 input logic [FIELD_W-1:0] year);
    case (mon)
      7'd2:                      return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtcIdxCtrl.sv
module rtcIdxCtrl
  import rtcIdxPkg::*;
#(
  parameter int TICKS_PER_SEC = 16,
  parameter int UIP_LEAD      = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickIn,
  input  logic      selWr,
  input  logic      dataWr,
  input  logic [7:0] wrData,
  input  logic [7:0] timeRd,
  output dpStrobe_t strobe,
  output logic [7:0] rdData,
  output logic      uipFlag,
  output logic      setBit,
  output logic      divHold
);
  localparam int PW = $clog2(TICKS_PER_SEC);
  localparam logic [PW-1:0] LAST_V  = PW'(TICKS_PER_SEC - 1);
  localparam logic [PW-1:0] HALF_V  = PW'(TICKS_PER_SEC / 2);
  localparam logic [PW-1:0] START_V = PW'(TICKS_PER_SEC - UIP_LEAD);

  logic [7:0]    idxQ;
  logic          setQ, binQ;
  logic [1:0]    divSelQ;
  logic [4:0]    rateQ;
  logic [PW-1:0] prescQ;
  logic          running;
  fieldSel_e     selField;

  assign divHold  = (divSelQ == 2'b11);
  assign setBit   = setQ;
  assign running  = !setQ && !divHold;
  assign uipFlag  = running && (prescQ >= START_V);
  assign selField = indexToField(idxQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ    <= 8'h00;
      setQ    <= 1'b0;
      binQ    <= 1'b0;
      divSelQ <= 2'b00;
      rateQ   <= 5'd0;
    end else begin
      if (selWr) idxQ <= wrData;
      if (dataWr && idxQ == IDX_CTL) begin
        setQ <= wrData[7];
        binQ <= wrData[2];
      end
      if (dataWr && idxQ == IDX_RATE) begin
        divSelQ <= wrData[6:5];
        rateQ   <= wrData[4:0];
      end
    end
  end

  // prescaler: held at the half-second point while the divider is in reset
  always_ff @(posedge clk) begin
    if (!rstN)        prescQ <= '0;
    else if (divHold) prescQ <= HALF_V;
    else if (tickIn)  prescQ <= (prescQ == LAST_V) ? '0 : prescQ + 1'b1;
  end

  always_comb begin
    strobe.advance = tickIn && running && (prescQ == LAST_V);
    strobe.wrEn    = dataWr;
    strobe.wrField = selField;
    strobe.rdField = selField;
    strobe.binMode = binQ;
  end

  always_comb begin
    case (idxQ)
      IDX_CTL:  rdData = {setQ, 4'b0000, binQ, 2'b00};
      IDX_RATE: rdData = {uipFlag, divSelQ, rateQ};
      default:  rdData = (selField != FLD_NONE) ? timeRd : 8'h00;
    endcase
  end
endmodule

// File: rtl/rtcIdxDatapath.sv
module rtcIdxDatapath
  import rtcIdxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [7:0] wrData,
  output logic [7:0] timeRd,
  output calTime_t   timeNow
);
  logic [FIELD_W-1:0] fieldQ [NUM_FIELDS];
  logic [FIELD_W-1:0] nextV  [NUM_FIELDS];
  logic [7:0]         bcdSum;
  logic [FIELD_W-1:0] wrBin;
  logic [FIELD_W-1:0] rdVal, tens, ones;

  assign bcdSum = 8'(wrData[7:4]) * 8'd10 + 8'(wrData[3:0]);
  assign wrBin  = strobe.binMode ? wrData[6:0] : bcdSum[6:0];

  // calendar carry chain
  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) nextV[i] = fieldQ[i];
    if (strobe.advance) begin
      if (fieldQ[IX_SEC] != 7'd59) nextV[IX_SEC] = fieldQ[IX_SEC] + 7'd1;
      else begin
        nextV[IX_SEC] = 7'd0;
        if (fieldQ[IX_MIN] != 7'd59) nextV[IX_MIN] = fieldQ[IX_MIN] + 7'd1;
        else begin
          nextV[IX_MIN] = 7'd0;
          if (fieldQ[IX_HOUR] != 7'd23) nextV[IX_HOUR] = fieldQ[IX_HOUR] + 7'd1;
          else begin
            nextV[IX_HOUR] = 7'd0;
            if (fieldQ[IX_DAY] < daysIn(fieldQ[IX_MON], fieldQ[IX_YEAR]))
              nextV[IX_DAY] = fieldQ[IX_DAY] + 7'd1;
            else begin
              nextV[IX_DAY] = 7'd1;
              if (fieldQ[IX_MON] < 7'd12) nextV[IX_MON] = fieldQ[IX_MON] + 7'd1;
              else begin
                nextV[IX_MON]  = 7'd1;
                nextV[IX_YEAR] = (fieldQ[IX_YEAR] == 7'd99) ? 7'd0 : fieldQ[IX_YEAR] + 7'd1;
              end
            end
          end
        end
      end
    end
  end

  // one register per field; a data write overrides that field's advance
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam logic [FIELD_W-1:0] RST_V =
      (f == IX_DAY || f == IX_MON) ? 7'd1 : 7'd0;
    always_ff @(posedge clk) begin
      if (!rstN) fieldQ[f] <= RST_V;
      else if (strobe.wrEn && strobe.wrField == fieldSel_e'(f)) fieldQ[f] <= wrBin;
      else fieldQ[f] <= nextV[f];
    end
  end

  always_comb begin
    case (strobe.rdField)
      FLD_SEC:  rdVal = fieldQ[IX_SEC];
      FLD_MIN:  rdVal = fieldQ[IX_MIN];
      FLD_HOUR: rdVal = fieldQ[IX_HOUR];
      FLD_DAY:  rdVal = fieldQ[IX_DAY];
      FLD_MON:  rdVal = fieldQ[IX_MON];
      FLD_YEAR: rdVal = fieldQ[IX_YEAR];
      default:  rdVal = 7'd0;
    endcase
  end

  assign tens   = rdVal / 7'd10;
  assign ones   = rdVal % 7'd10;
  assign timeRd = strobe.binMode ? {1'b0, rdVal} : {tens[3:0], ones[3:0]};

  always_comb begin
    timeNow.sec  = fieldQ[IX_SEC];
    timeNow.min  = fieldQ[IX_MIN];
    timeNow.hour = fieldQ[IX_HOUR];
    timeNow.day  = fieldQ[IX_DAY];
    timeNow.mon  = fieldQ[IX_MON];
    timeNow.year = fieldQ[IX_YEAR];
  end
endmodule

// File: rtl/rtcIdxCore.sv
module rtcIdxCore
  import rtcIdxPkg::*;
#(
  parameter int TICKS_PER_SEC = 16,
  parameter int UIP_LEAD      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       selWr,
  input  logic       dataWr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  dpStrobe_t  strobe;
  calTime_t   timeNow;
  logic [7:0] timeRd;
  logic       uipFlag, setBit, divHold;

  rtcIdxCtrl #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_LEAD(UIP_LEAD)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .selWr(selWr), .dataWr(dataWr),
    .wrData(wrData), .timeRd(timeRd), .strobe(strobe), .rdData(rdData),
    .uipFlag(uipFlag), .setBit(setBit), .divHold(divHold)
  );

  rtcIdxDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .timeRd(timeRd), .timeNow(timeNow)
  );
endmodule

// File: rtl/rtcIdxChecker.sv
module rtcIdxChecker
  import rtcIdxPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input calTime_t  timeNow,
  input dpStrobe_t strobe,
  input logic      uip,
  input logic      setBit,
  input logic      divHold
);
  logic timeWr, inRange;

  assign timeWr  = strobe.wrEn && (strobe.wrField != FLD_NONE);
  assign inRange = (timeNow.sec < 7'd60) && (timeNow.min < 7'd60) &&
                   (timeNow.hour < 7'd24) && (timeNow.mon >= 7'd1) &&
                   (timeNow.mon <= 7'd12) && (timeNow.year <= 7'd99) &&
                   (timeNow.day >= 7'd1) &&
                   (timeNow.day <= daysIn(timeNow.mon, timeNow.year));

  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    (setBit && !timeWr) |=> $stable(timeNow));

  assert_divhold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (divHold && !timeWr) |=> $stable(timeNow));

  assert_uip_running_R7: assert property (@(posedge clk) disable iff (!rstN)
    uip |-> (!setBit && !divHold));

  assert_uip_guard_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!uip && !timeWr) |=> $stable(timeNow));

  assert_range_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inRange && !timeWr) |=> inRange);
endmodule

bind rtcIdxCore rtcIdxChecker u_rtcIdxChecker (
  .clk(clk), .rstN(rstN), .timeNow(timeNow), .strobe(strobe),
  .uip(uipFlag), .setBit(setBit), .divHold(divHold)
);

// File: tb/rtcIdxCore_bench.sv
module rtcIdxCore_bench;
  localparam int TPS  = 16;
  localparam int LEAD = 2;
  localparam int HALF = TPS / 2;

  logic clk = 1'b0, rstN = 1'b0, tickIn = 1'b0, selWr = 1'b0, dataWr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  bit tickRun = 1'b0;
  int checks = 0, fails = 0, tickCount = 0;

  // behavioural model state
  int mSec, mMin, mHour, mDay, mMon, mYear, mSet, mBin, mDiv, mRate, mIdx, mPresc;
  int oldIdx, oldBin; bit hold, adv;

  rtcIdxCore #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) u_rtcIdxCore (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .selWr(selWr), .dataWr(dataWr),
    .wrData(wrData), .rdData(rdData)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int dim(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int enc(input int v);
    return mBin ? v : (((v / 10) % 16) * 16 + v % 10);
  endfunction

  function automatic int modelRead(input int idx);
    int uip;
    uip = (!mSet && mDiv != 3 && mPresc >= TPS - LEAD) ? 1 : 0;
    case (idx)
      'h00: return enc(mSec);
      'h02: return enc(mMin);
      'h04: return enc(mHour);
      'h07: return enc(mDay);
      'h08: return enc(mMon);
      'h09: return enc(mYear);
      'h0A: return uip * 128 + mDiv * 32 + mRate;
      'h0B: return mSet * 128 + mBin * 4;
      default: return 0;
    endcase
  endfunction

  task automatic modelAdvance;
    if (mSec < 59) mSec++;
    else begin
      mSec = 0;
      if (mMin < 59) mMin++;
      else begin
        mMin = 0;
        if (mHour < 23) mHour++;
        else begin
          mHour = 0;
          if (mDay < dim(mMon, mYear)) mDay++;
          else begin
            mDay = 1;
            if (mMon < 12) mMon++;
            else begin mMon = 1; mYear = (mYear == 99) ? 0 : mYear + 1; end
          end
        end
      end
    end
  endtask

  task automatic modelWrite(input int idx, input int d, input int bin);
    int v;
    v = bin ? (d & 127) : (((d >> 4) * 10 + (d & 15)) & 127);
    case (idx)
      'h00: mSec = v;  'h02: mMin = v;  'h04: mHour = v;
      'h07: mDay = v;  'h08: mMon = v;  'h09: mYear = v;
      'h0A: begin mDiv = (d >> 5) & 3; mRate = d & 31; end
      'h0B: begin mSet = (d >> 7) & 1; mBin = (d >> 2) & 1; end
      default: ;
    endcase
  endtask

  // model steps on each edge; outputs compared 5 ns later
  always @(posedge clk) begin
    if (!rstN) begin
      mSec = 0; mMin = 0; mHour = 0; mDay = 1; mMon = 1; mYear = 0;
      mSet = 0; mBin = 0; mDiv = 0; mRate = 0; mIdx = 0; mPresc = 0;
    end else begin
      oldIdx = mIdx; oldBin = mBin;
      hold = (mDiv == 3);
      adv  = tickIn && !hold && !mSet && (mPresc == TPS - 1);
      if (tickIn) tickCount++;
      if (hold) mPresc = HALF;
      else if (tickIn) mPresc = (mPresc == TPS - 1) ? 0 : mPresc + 1;
      if (adv) modelAdvance();
      if (dataWr) modelWrite(oldIdx, wrData, oldBin);
      if (selWr) mIdx = wrData;
    end
    #5;
    if (rstN) check("R1 per-cycle model", rdData, modelRead(mIdx));
  end

  initial begin
    forever begin
      @(negedge clk);
      tickIn = tickRun ? ~tickIn : 1'b0;
    end
  end

  task automatic selIdx(input int i);
    @(negedge clk); selWr = 1'b1; wrData = 8'(i);
    @(negedge clk); selWr = 1'b0;
  endtask

  task automatic wrReg(input int i, input int d);
    selIdx(i);
    dataWr = 1'b1; wrData = 8'(d);
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic rdReg(input int i, output int v);
    selIdx(i);
    v = rdData;
  endtask

  // freeze + hold, load BCD fields, clear freeze, then release divider
  task automatic setTime(input int h, input int m, input int s,
                         input int d, input int mo, input int y, output int relTick);
    wrReg('h0B, 'h80); wrReg('h0A, 'h60);
    wrReg('h00, s); wrReg('h02, m); wrReg('h04, h);
    wrReg('h07, d); wrReg('h08, mo); wrReg('h09, y);
    wrReg('h0B, 'h00); wrReg('h0A, 'h00);
    relTick = tickCount;
  endtask

  task automatic waitSecChange(output int atTick);
    int old;
    selIdx('h00);
    old = rdData;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (rdData != old) break;
    end
    atTick = tickCount;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    summary();
  end

  initial begin
    int v, rel, t1, t2, t0;
    repeat (3) @(negedge clk);
    check("R2 seconds at reset", rdData, 'h00);
    rstN = 1'b1;
    rdReg('h07, v); check("R2 day at reset", v, 'h01);
    rdReg('h08, v); check("R2 month at reset", v, 'h01);
    rdReg('h0B, v); check("R2 control at reset", v, 'h00);
    rdReg('h0A, v); check("R2 rate/status at reset", v, 'h00);

    tickRun = 1'b1;
    setTime('h23, 'h59, 'h58, 'h31, 'h12, 'h99, rel);
    waitSecChange(t1);
    check("R6 half-second first update (ticks)", t1 - rel, HALF);
    check("R6 seconds after first update", rdData, 'h59);
    waitSecChange(t2);
    check("R6 full-second period (ticks)", t2 - t1, TPS);
    check("R8 seconds wrap", rdData, 'h00);
    rdReg('h02, v); check("R8 minutes wrap", v, 'h00);
    rdReg('h04, v); check("R8 hours wrap", v, 'h00);
    rdReg('h07, v); check("R8 day wrap", v, 'h01);
    rdReg('h08, v); check("R8 month wrap", v, 'h01);
    rdReg('h09, v); check("R8 year 99 wraps to 00", v, 'h00);

    // R7: flag lead
    selIdx('h0A);
    for (int c = 0; c < 200 && rdData[7] == 1'b0; c++) @(negedge clk);
    t0 = tickCount;
    for (int c = 0; c < 200 && rdData[7] == 1'b1; c++) @(negedge clk);
    check("R7 update flag lead (ticks)", tickCount - t0, LEAD);

    // R4: freeze
    wrReg('h0B, 'h80);
    rdReg('h00, t0);
    repeat (80) @(negedge clk);
    check("R4 seconds frozen", rdData, t0);
    rdReg('h0A, v); check("R4 flag low while frozen", v & 'h80, 0);
    wrReg('h0B, 'h00);

    // R5: divider held
    wrReg('h0A, 'h60);
    rdReg('h00, t0);
    repeat (80) @(negedge clk);
    check("R5 seconds held by divider reset", rdData, t0);
    rdReg('h0A, v); check("R5 flag low under divider reset", v, 'h60);

    // R3: formats
    wrReg('h0B, 'h84);
    wrReg('h00, 'h2D);
    rdReg('h00, v); check("R3 binary readback", v, 'h2D);
    wrReg('h0B, 'h80);
    rdReg('h00, v); check("R3 same value in BCD", v, 'h45);
    wrReg('h00, 'h17);
    wrReg('h0B, 'h84);
    rdReg('h00, v); check("R3 BCD write read in binary", v, 17);

    // R10: read-only flag, unused control bits
    wrReg('h0A, 'hE3);
    rdReg('h0A, v); check("R10 flag write ignored", v, 'h63);
    wrReg('h0B, 'hFF);
    rdReg('h0B, v); check("R10 control unused bits", v, 'h84);
    wrReg('h0B, 'h80);

    // R1: unmapped index
    wrReg('h05, 'h33);
    rdReg('h05, v); check("R1 unmapped index reads zero", v, 'h00);
    rdReg('h00, v); check("R1 unmapped write leaves seconds", v, 'h17);

    // R8 minute/hour carry
    setTime('h10, 'h59, 'h59, 'h15, 'h06, 'h21, rel);
    waitSecChange(t1);
    rdReg('h02, v); check("R8 minute carry", v, 'h00);
    rdReg('h04, v); check("R8 hour carry", v, 'h11);

    // R9: month lengths
    setTime('h23, 'h59, 'h59, 'h28, 'h02, 'h04, rel);
    waitSecChange(t1);
    rdReg('h07, v); check("R9 Feb 28 leap -> 29", v, 'h29);
    rdReg('h08, v); check("R9 stays February", v, 'h02);
    setTime('h23, 'h59, 'h59, 'h29, 'h02, 'h04, rel);
    waitSecChange(t1);
    rdReg('h07, v); check("R9 Feb 29 -> day 1", v, 'h01);
    rdReg('h08, v); check("R9 Feb 29 -> March", v, 'h03);
    setTime('h23, 'h59, 'h59, 'h28, 'h02, 'h05, rel);
    waitSecChange(t1);
    rdReg('h07, v); check("R9 Feb 28 common -> day 1", v, 'h01);
    rdReg('h08, v); check("R9 Feb 28 common -> March", v, 'h03);
    setTime('h23, 'h59, 'h59, 'h30, 'h04, 'h21, rel);
    waitSecChange(t1);
    rdReg('h07, v); check("R9 Apr 30 -> day 1", v, 'h01);
    rdReg('h08, v); check("R9 Apr 30 -> May", v, 'h05);
    setTime('h23, 'h59, 'h59, 'h30, 'h05, 'h21, rel);
    waitSecChange(t1);
    rdReg('h07, v); check("R9 May 30 -> 31", v, 'h31);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule